// File: doc/BRIEF.md
# Transactional Overflow Table Controller

This block keeps a hash table of transactional cache lines in uncached memory. When the cache has to evict a transactional line from a set that has overflowed, it inserts the line here. When a request misses the resident tags of an overflowed set, the cache asks for a lookup. A found line comes back to the cache and leaves the table, and the cache's victim line goes into the table in its place. When no slot is free, the block raises an exception so that software can enlarge the table and retry the transaction.

Software places the table with a base address and a size given as a power of two. The hash index is the low-order bits of the line address. Collisions probe the next slot, wrapping from the last slot back to slot 0. A clear command walks every slot and empties it. The commit variant first writes each held line back to its home address. The abort variant discards the lines. While any operation is running, the block refuses incoming coherence interventions with a NACK so that they retry later.

Top module: `ohc_top`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_valid`, `ovf_exc`, `mem_en` and `intv_nack` are 0.
- R2: The table has 2^`cfg_size_log2` slots. Slot i is the memory word at `cfg_base`+i. A slot word holds the state in its top 2 bits (0 empty, 1 full, 2 removed), then the AW-bit line address, then the DW-bit data in the low bits. Both configuration inputs are sampled when a request is accepted.
- R3: Insert (`req_op`=1) begins at slot index `req_addr` mod 2^`cfg_size_log2`. It writes {full, address, data} into the first slot that is not full.
- R4: Probing moves to the next slot and wraps from the last slot to slot 0.
- R5: Lookup (`req_op`=0) of a line held in a full slot answers with `rsp_hit`=1 and the line's data. It then marks that slot as removed, keeping its address and data.
- R6: A lookup stops at the first empty slot and answers a miss. With one probe, `rsp_valid` rises 2 cycles after the accepting edge, and each further probe adds 2 cycles.
- R7: A lookup that has visited every slot without a match answers a miss. Removed slots do not stop the probe.
- R8: A lookup that hits with `req_vic_valid`=1 then inserts the victim line, probing from the victim's own hash index. The response carries the hit and the found data.
- R9: An insert that finds every slot full pulses `ovf_exc` together with `rsp_valid`, with `rsp_hit`=0, and leaves the table unchanged.
- R10: `intv_nack` equals `intv_valid` while an operation is running and is 0 while idle.
- R11: Commit clear (`req_op`=2) writes the data of every full slot to memory at that slot's line address, with the upper bits zero. It then sets every slot to 0.
- R12: Abort clear (`req_op`=3) sets every slot to 0 and writes nothing to any home address.
- R13: Only one operation runs at a time. `req_ready` is 0 while an operation runs, and `rsp_valid` is a single-cycle pulse for each request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | AW | Memory word address of slot 0 |
| cfg_size_log2 | input | LW | log2 of the slot count (at most IW) |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Controller idle, request accepted |
| req_op | input | 2 | 0 lookup, 1 insert, 2 commit clear, 3 abort clear |
| req_addr | input | AW | Line address to look up or insert |
| req_data | input | DW | Line data for insert |
| req_vic_valid | input | 1 | Lookup carries a victim line to swap in |
| req_vic_addr | input | AW | Victim line address |
| req_vic_data | input | DW | Victim line data |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | Lookup found the line |
| rsp_data | output | DW | Found line data (0 otherwise) |
| ovf_exc | output | 1 | Table full on insert |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | SW | Memory write data |
| mem_rdata | input | SW | Read data, valid the cycle after a read |
| intv_valid | input | 1 | Incoming coherence intervention |
| intv_nack | output | 1 | Intervention refused |

## Verification
The embedded assertions check several rules on every cycle: the one-cycle response pulse, the absence of memory traffic while idle, that a memory access always coincides with a NACK to a present intervention, the pairing of the exception with a non-hit response, home writes only during a commit walk, and the wrap of the probe pointer. The bench scenarios show what a cycle rule cannot. These are where inserts land after collisions and wraps, the memory contents after a swap, the exact probe latencies that tell an early stop at an empty slot from a full scan, the unchanged table after an exception, and the home-address contents after commit versus abort.

// File: rtl/ohc_pkg.sv
package ohc_pkg;
  typedef enum logic [1:0] {
    OP_LOOKUP = 2'd0,
    OP_INSERT = 2'd1,
    OP_COMMIT = 2'd2,
    OP_ABORT  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    SL_EMPTY = 2'd0,
    SL_FULL  = 2'd1,
    SL_GONE  = 2'd2
  } slot_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_READ,
    S_CHECK,
    S_HOME,
    S_WRITE
  } fsm_e;
endpackage

// File: rtl/ohc_probe.sv
// Probe pointer: slot index plus count of slots visited.
module ohc_probe #(
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [IW-1:0] start_idx,
  input  logic [IW-1:0] mask,
  output logic [IW-1:0] idx,
  output logic [IW:0]   cnt
);
  logic [IW-1:0] idx_d;
  logic [IW:0]   cnt_d;
  logic          en;

  assign en = load | step;

  always_comb begin
    if (load) begin
      idx_d = start_idx;
      cnt_d = '0;
    end else begin
      idx_d = (idx + IW'(1)) & mask;
      cnt_d = cnt + (IW+1)'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
      cnt <= '0;
    end else if (en) begin
      idx <= idx_d;
      cnt <= cnt_d;
    end
  end

  // R4: stepping past the last slot lands on slot 0
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && idx == mask) |=> (idx == '0));
endmodule

// File: rtl/ohc_memport.sv
// Memory port mux: slot read, slot write, home write-back.
module ohc_memport
  import ohc_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter int IW = 4,
  localparam int SW = 2 + AW + DW
) (
  input  fsm_e          st,
  input  op_e           op,
  input  logic [AW-1:0] base,
  input  logic [IW-1:0] idx,
  input  logic [SW-1:0] slot,
  input  logic [AW-1:0] line_addr,
  input  logic [DW-1:0] line_data,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [SW-1:0] mem_wdata
);
  logic [AW-1:0] slot_addr;

  assign slot_addr = base + AW'(idx);

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = slot_addr;
    mem_wdata = '0;
    case (st)
      S_READ: mem_en = 1'b1;
      S_HOME: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = slot[DW +: AW];
        mem_wdata = {{(SW-DW){1'b0}}, slot[DW-1:0]};
      end
      S_WRITE: begin
        mem_en = 1'b1;
        mem_we = 1'b1;
        case (op)
          OP_LOOKUP: mem_wdata = {SL_GONE, slot[AW+DW-1:0]};
          OP_INSERT: mem_wdata = {SL_FULL, line_addr, line_data};
          default:   mem_wdata = '0;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ohc_top.sv
module ohc_top
  import ohc_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter int IW = 4,
  localparam int LW = $clog2(IW + 1),
  localparam int SW = 2 + AW + DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_base,
  input  logic [LW-1:0] cfg_size_log2,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          req_vic_valid,
  input  logic [AW-1:0] req_vic_addr,
  input  logic [DW-1:0] req_vic_data,
  output logic          rsp_valid,
  output logic          rsp_hit,
  output logic [DW-1:0] rsp_data,
  output logic          ovf_exc,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [SW-1:0] mem_wdata,
  input  logic [SW-1:0] mem_rdata,
  input  logic          intv_valid,
  output logic          intv_nack
);
  fsm_e          st_q, st_d;
  op_e           op_q, op_d;
  logic [AW-1:0] addr_q, addr_d, va_q, va_d, base_q, base_d;
  logic [DW-1:0] data_q, data_d, vd_q, vd_d, fd_q, fd_d, rdat_q, rdat_d;
  logic          vv_q, vv_d, hit_q, hit_d, rv_q, rv_d, rh_q, rh_d, re_q, re_d;
  logic [SW-1:0] slot_q, slot_d;
  logic [LW-1:0] log_q, log_d;

  logic [IW:0]   sz_q, cfg_sz;
  logic [IW-1:0] mask_q, cfg_mask, idx, ld_idx;
  logic [IW:0]   cnt;
  logic          ld, stp, fin, last;

  slot_e         rd_st;
  logic [AW-1:0] rd_tag;
  logic [DW-1:0] rd_data;

  assign cfg_sz   = (IW+1)'(1) << cfg_size_log2;
  assign cfg_mask = IW'(cfg_sz - (IW+1)'(1));
  assign sz_q     = (IW+1)'(1) << log_q;
  assign mask_q   = IW'(sz_q - (IW+1)'(1));
  assign last     = (cnt == sz_q - (IW+1)'(1));

  assign rd_st   = slot_e'(mem_rdata[SW-1 -: 2]);
  assign rd_tag  = mem_rdata[DW +: AW];
  assign rd_data = mem_rdata[DW-1:0];

  ohc_probe #(.IW(IW)) u_probe (
    .clk(clk), .rst_n(rst_n), .load(ld), .step(stp),
    .start_idx(ld_idx), .mask(mask_q), .idx(idx), .cnt(cnt)
  );

  ohc_memport #(.AW(AW), .DW(DW), .IW(IW)) u_mem (
    .st(st_q), .op(op_q), .base(base_q), .idx(idx), .slot(slot_q),
    .line_addr(addr_q), .line_data(data_q),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  // next-state logic
  always_comb begin
    st_d = st_q;   op_d = op_q;   addr_d = addr_q; data_d = data_q;
    vv_d = vv_q;   va_d = va_q;   vd_d = vd_q;     hit_d = hit_q;
    fd_d = fd_q;   slot_d = slot_q; base_d = base_q; log_d = log_q;
    re_d = 1'b0;   ld = 1'b0;     ld_idx = '0;     stp = 1'b0;
    fin  = 1'b0;
    case (st_q)
      S_IDLE: if (req_valid) begin
        op_d   = op_e'(req_op);
        addr_d = req_addr;      data_d = req_data;
        vv_d   = req_vic_valid; va_d = req_vic_addr; vd_d = req_vic_data;
        hit_d  = 1'b0;          fd_d = '0;
        base_d = cfg_base;      log_d = cfg_size_log2;
        ld     = 1'b1;
        ld_idx = (req_op[1] == 1'b0) ? (req_addr[IW-1:0] & cfg_mask) : '0;
        st_d   = S_READ;
      end
      S_READ: st_d = S_CHECK;
      S_CHECK: begin
        slot_d = mem_rdata;
        case (op_q)
          OP_LOOKUP:
            if (rd_st == SL_FULL && rd_tag == addr_q) begin
              hit_d = 1'b1;
              fd_d  = rd_data;
              st_d  = S_WRITE;
            end else if (rd_st == SL_EMPTY || last) fin = 1'b1;
            else begin stp = 1'b1; st_d = S_READ; end
          OP_INSERT:
            if (rd_st != SL_FULL) st_d = S_WRITE;
            else if (last) begin fin = 1'b1; re_d = 1'b1; end
            else begin stp = 1'b1; st_d = S_READ; end
          OP_COMMIT: st_d = (rd_st == SL_FULL) ? S_HOME : S_WRITE;
          default:   st_d = S_WRITE;
        endcase
      end
      S_HOME: st_d = S_WRITE;
      S_WRITE:
        case (op_q)
          OP_LOOKUP:
            if (vv_q) begin
              op_d   = OP_INSERT;
              addr_d = va_q;
              data_d = vd_q;
              vv_d   = 1'b0;
              ld     = 1'b1;
              ld_idx = va_q[IW-1:0] & mask_q;
              st_d   = S_READ;
            end else fin = 1'b1;
          OP_INSERT: fin = 1'b1;
          default:
            if (last) fin = 1'b1;
            else begin stp = 1'b1; st_d = S_READ; end
        endcase
      default: st_d = S_IDLE;
    endcase
    if (fin) st_d = S_IDLE;
    rv_d   = fin;
    rh_d   = fin & hit_q;
    rdat_d = fin ? fd_q : '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;  op_q <= OP_LOOKUP; addr_q <= '0; data_q <= '0;
      vv_q <= 1'b0;    va_q <= '0;        vd_q <= '0;   hit_q <= 1'b0;
      fd_q <= '0;      slot_q <= '0;      base_q <= '0; log_q <= '0;
      rv_q <= 1'b0;    rh_q <= 1'b0;      rdat_q <= '0; re_q <= 1'b0;
    end else begin
      st_q <= st_d;    op_q <= op_d;      addr_q <= addr_d; data_q <= data_d;
      vv_q <= vv_d;    va_q <= va_d;      vd_q <= vd_d;     hit_q <= hit_d;
      fd_q <= fd_d;    slot_q <= slot_d;  base_q <= base_d; log_q <= log_d;
      rv_q <= rv_d;    rh_q <= rh_d;      rdat_q <= rdat_d; re_q <= re_d;
    end
  end

  assign req_ready = (st_q == S_IDLE);
  assign rsp_valid = rv_q;
  assign rsp_hit   = rh_q;
  assign rsp_data  = rdat_q;
  assign ovf_exc   = re_q;
  assign intv_nack = intv_valid && (st_q != S_IDLE);

  // R13: response is a one-cycle pulse
  a_r13_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R13: no memory traffic while idle
  a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_en);
  // R10: every memory access happens under NACK cover
  a_r10_nack_cover: assert property (@(posedge clk) disable iff (!rst_n)
    (intv_valid && mem_en) |-> intv_nack);
  // R9: exception only alongside a non-hit response
  a_r9_exc_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_exc |-> (rsp_valid && !rsp_hit));
  // R12: home write-back only in a commit walk
  a_r12_home_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_HOME) |-> (op_q == OP_COMMIT));
endmodule

// File: tb/ohc_top_tb.sv
`timescale 1ns/1ps
module ohc_top_tb;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int IW = 4;
  localparam int LW = $clog2(IW + 1);
  localparam int SW = 2 + AW + DW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] cfg_base;
  logic [LW-1:0] cfg_size_log2;
  logic          req_valid, req_ready, req_vic_valid;
  logic [1:0]    req_op;
  logic [AW-1:0] req_addr, req_vic_addr, mem_addr;
  logic [DW-1:0] req_data, req_vic_data, rsp_data;
  logic          rsp_valid, rsp_hit, ovf_exc, mem_en, mem_we, intv_valid, intv_nack;
  logic [SW-1:0] mem_wdata, mem_rdata;
  logic [SW-1:0] mem [0:(1<<AW)-1];

  int n_vec = 0;
  int n_bad = 0;

  typedef struct {
    logic          hit;
    logic [DW-1:0] data;
    logic          exc;
    string         rq;
  } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  ohc_top #(.AW(AW), .DW(DW), .IW(IW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_size_log2(cfg_size_log2),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .req_vic_valid(req_vic_valid),
    .req_vic_addr(req_vic_addr), .req_vic_data(req_vic_data),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data), .ovf_exc(ovf_exc),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .intv_valid(intv_valid), .intv_nack(intv_nack)
  );

  // uncached memory model, one-cycle read latency
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr];
    end
  end

  task automatic check(input logic ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] slotw(input logic [1:0] s, input logic [AW-1:0] a, input logic [DW-1:0] d);
    return {s, a, d};
  endfunction

  task automatic chk_mem(input logic [AW-1:0] a, input logic [SW-1:0] e, input string rq);
    check(mem[a] === e, rq, 64'(mem[a]), 64'(e));
  endtask

  // monitor: pops expected responses
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb_q.size() == 0) check(1'b0, "R13 unexpected response", 1, 0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        check(rsp_hit === e.hit, {e.rq, " hit"}, 64'(rsp_hit), 64'(e.hit));
        check(rsp_data === e.data, {e.rq, " data"}, 64'(rsp_data), 64'(e.data));
        check(ovf_exc === e.exc, {e.rq, " exc"}, 64'(ovf_exc), 64'(e.exc));
      end
    end
  end

  // driver: pushes expectation, applies request, returns latency
  task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic vv, input logic [AW-1:0] va, input logic [DW-1:0] vd,
                       input logic eh, input logic [DW-1:0] ed, input logic ee,
                       input string rq, output int lat);
    exp_t e;
    e.hit = eh; e.data = ed; e.exc = ee; e.rq = rq;
    sb_q.push_back(e);
    req_op = op; req_addr = a; req_data = d;
    req_vic_valid = vv; req_vic_addr = va; req_vic_data = vd;
    req_valid = 1'b1;
    lat = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      lat++;
      if (lat == 1) begin
        req_valid = 1'b0;
        if (!rsp_valid) begin
          check(intv_nack === 1'b1, "R10 nack while busy", 64'(intv_nack), 1);
          check(req_ready === 1'b0, "R13 busy not ready", 64'(req_ready), 0);
        end
      end
      if (rsp_valid) break;
    end
    @(negedge clk);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    summary();
  end

  initial begin
    int lat;
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_data = '0;
    req_vic_valid = 1'b0; req_vic_addr = '0; req_vic_data = '0;
    cfg_base = 12'h100; cfg_size_log2 = 3'd2; intv_valid = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(req_ready === 1'b1, "R1 ready", 64'(req_ready), 1);
    check(rsp_valid === 1'b0, "R1 rsp_valid", 64'(rsp_valid), 0);
    check(ovf_exc === 1'b0, "R1 exc", 64'(ovf_exc), 0);
    check(mem_en === 1'b0, "R1 mem_en", 64'(mem_en), 0);
    check(intv_nack === 1'b0, "R10 idle no nack", 64'(intv_nack), 0);

    // R2 R3 insert at hash slot
    issue(2'd1, 12'h011, 16'hAAAA, 0, 0, 0, 0, 0, 0, "R3 insert A", lat);
    chk_mem(12'h101, slotw(2'd1, 12'h011, 16'hAAAA), "R2 slot word A");
    issue(2'd1, 12'h021, 16'hBBBB, 0, 0, 0, 0, 0, 0, "R3 insert B", lat);
    chk_mem(12'h102, slotw(2'd1, 12'h021, 16'hBBBB), "R3 collision next slot");
    issue(2'd1, 12'h013, 16'hCCCC, 0, 0, 0, 0, 0, 0, "R3 insert C", lat);
    issue(2'd1, 12'h033, 16'hDDDD, 0, 0, 0, 0, 0, 0, "R4 insert D", lat);
    chk_mem(12'h103, slotw(2'd1, 12'h013, 16'hCCCC), "R3 slot C");
    chk_mem(12'h100, slotw(2'd1, 12'h033, 16'hDDDD), "R4 wrap to slot 0");

    // R9 full table
    issue(2'd1, 12'h041, 16'hEEEE, 0, 0, 0, 0, 0, 1, "R9 full exc", lat);
    chk_mem(12'h101, slotw(2'd1, 12'h011, 16'hAAAA), "R9 unchanged s1");
    chk_mem(12'h100, slotw(2'd1, 12'h033, 16'hDDDD), "R9 unchanged s0");

    // R5 hit removes slot
    issue(2'd0, 12'h021, 0, 0, 0, 0, 1, 16'hBBBB, 0, "R5 lookup B", lat);
    chk_mem(12'h102, slotw(2'd2, 12'h021, 16'hBBBB), "R5 slot removed");

    // R7 full scan miss: 4 probes
    issue(2'd0, 12'h051, 0, 0, 0, 0, 0, 0, 0, "R7 miss scan", lat);
    check(lat == 9, "R7 scan latency", 64'(lat), 9);

    // R8 swap victim in
    issue(2'd0, 12'h011, 0, 1, 12'h061, 16'h6666, 1, 16'hAAAA, 0, "R8 swap hit", lat);
    chk_mem(12'h101, slotw(2'd1, 12'h061, 16'h6666), "R8 victim placed");
    chk_mem(12'h102, slotw(2'd2, 12'h021, 16'hBBBB), "R8 other removed kept");

    // R11 commit write-back
    issue(2'd2, 0, 0, 0, 0, 0, 0, 0, 0, "R11 commit", lat);
    chk_mem(12'h033, slotw(2'd0, 12'h000, 16'hDDDD), "R11 home D");
    chk_mem(12'h061, slotw(2'd0, 12'h000, 16'h6666), "R11 home V");
    chk_mem(12'h013, slotw(2'd0, 12'h000, 16'hCCCC), "R11 home C");
    chk_mem(12'h021, '0, "R11 removed not written");
    for (int i = 0; i < 4; i++) chk_mem(12'h100 + 12'(i), '0, "R11 slot cleared");

    // R12 abort discards
    issue(2'd1, 12'h082, 16'h8888, 0, 0, 0, 0, 0, 0, "R12 pre insert", lat);
    chk_mem(12'h102, slotw(2'd1, 12'h082, 16'h8888), "R3 insert F");
    issue(2'd3, 0, 0, 0, 0, 0, 0, 0, 0, "R12 abort", lat);
    chk_mem(12'h102, '0, "R12 slot cleared");
    chk_mem(12'h082, '0, "R12 no home write");

    // R6 early stop at empty slot
    issue(2'd0, 12'h013, 0, 0, 0, 0, 0, 0, 0, "R6 miss empty", lat);
    check(lat == 3, "R6 one-probe latency", 64'(lat), 3);
    issue(2'd1, 12'h0A1, 16'h1234, 0, 0, 0, 0, 0, 0, "R3 insert G", lat);
    issue(2'd0, 12'h0B1, 0, 0, 0, 0, 0, 0, 0, "R6 miss after mismatch", lat);
    check(lat == 5, "R6 two-probe latency", 64'(lat), 5);

    // R2 R4 second table geometry
    cfg_base = 12'h200; cfg_size_log2 = 3'd1;
    issue(2'd1, 12'h005, 16'h5555, 0, 0, 0, 0, 0, 0, "R2 small insert", lat);
    issue(2'd1, 12'h007, 16'h7777, 0, 0, 0, 0, 0, 0, "R4 small wrap", lat);
    chk_mem(12'h201, slotw(2'd1, 12'h005, 16'h5555), "R2 base+1");
    chk_mem(12'h200, slotw(2'd1, 12'h007, 16'h7777), "R4 wrap small");
    issue(2'd1, 12'h009, 16'h9999, 0, 0, 0, 0, 0, 1, "R9 small full", lat);
    chk_mem(12'h202, '0, "R2 no write past table");

    check(sb_q.size() == 0, "R13 all responses seen", 64'(sb_q.size()), 0);
    check(intv_nack === 1'b0, "R10 idle at end", 64'(intv_nack), 0);
    summary();
  end
endmodule